// File: doc/BRIEF.md
# Serial FIFO Request Router

This block turns the fill levels and event pulses of one serial channel's transmit and receive FIFOs into interrupt and DMA request lines. It keeps two level-derived data flags (receive data ready, transmit space available) and four sticky event flags (receive control word arrived, transmit control word consumed, receive overrun, transmit underrun). It also holds four enables, one routing bit and two 4-bit watermarks, all reached through a small register port.

With the routing bit clear, each data flag and its control flag share one CPU interrupt line per direction, and software reads status to find the cause. With the routing bit set, the data flags drive dedicated receive and transmit DMA request lines instead. The control flags stay on the CPU lines and never reach a DMA request. The data flags follow the FIFO levels against the watermarks, so they drop by themselves as the FIFOs are drained or filled.

Top module: `sfir_top`

## Requirements
- R1: After a synchronous active-low reset every request output is 0, the control register (address 0) reads 0x00, the watermark register (address 1) reads 0x88 (transmit watermark in bits 7:4, receive watermark in bits 3:0), and status (address 2) reads 0x00 while the receive level is below 8 and the transmit level is at or above 8.
- R2: Status bit 0 (receive data ready) is 1 one cycle after the receive level is at or above the receive watermark, and returns to 0 by itself one cycle after the level drops below it.
- R3: Status bit 1 (transmit space available) is 1 one cycle after the transmit level is below the transmit watermark, and returns to 0 by itself one cycle after the level reaches or exceeds it.
- R4: Status bits 2 (receive control word) and 3 (transmit control word) set on a one-cycle event pulse, stay set, and clear only when 1 is written to that bit at address 2; a pulse in the same cycle as the clearing write leaves the bit set.
- R5: Status bits 4 (receive overrun) and 5 (transmit underrun) behave the same way, and each drives its own interrupt output whenever set, with no enable.
- R6: With control bit 4 (routing) at 0, irq_rx is the OR of (bit 0 ready and control bit 0 enable) and (bit 2 and control bit 1 enable); irq_tx likewise uses status bits 1 and 3 with control bits 2 and 3; both DMA request lines stay 0.
- R7: With routing at 1, enabled data flags drive dma_rx_req and dma_tx_req and no longer contribute to irq_rx or irq_tx.
- R8: A control-word flag never raises a DMA request in either routing mode.
- R9: Clearing an enable removes its contribution from the outputs without altering any status flag.
- R10: Every request output is registered: a status or control change becomes visible on the outputs one cycle after it is taken, so a level change reaches the outputs two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_ctl_evt | input | 1 | Pulse: receive control word arrived |
| tx_ctl_evt | input | 1 | Pulse: transmit control word consumed |
| rx_ovr_evt | input | 1 | Pulse: receive overrun |
| tx_udr_evt | input | 1 | Pulse: transmit underrun |
| reg_addr | input | 2 | Register select: 0 control, 1 watermarks, 2 status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 2*WM_W | Write data |
| reg_rdata | output | 2*WM_W | Read data for reg_addr (combinational) |
| irq_rx_ovr | output | 1 | Receive overrun interrupt |
| irq_tx_udr | output | 1 | Transmit underrun interrupt |
| irq_rx | output | 1 | Receive interrupt (data or control) |
| irq_tx | output | 1 | Transmit interrupt (data or control) |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
A level change is captured into status at the next edge and reaches the request outputs at the edge after that. An event pulse or a register write is taken at one edge and shows on the outputs at the following edge, while status reads are combinational and valid right after the capturing edge. The bench drives and samples half a period away from the edges, counts edges to these due points before queuing each expected value, and checks one output once a cycle early to pin the registered latency.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

    localparam int NUM_EVT       = 4;
    localparam int EVT_RX_CTL    = 0;
    localparam int EVT_TX_CTL    = 1;
    localparam int EVT_RX_OVR    = 2;
    localparam int EVT_TX_UDR    = 3;
    localparam int STAT_EVT_LSB  = 2;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_WM   = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic dma_route;
        logic tx_ctl_en;
        logic tx_data_en;
        logic rx_ctl_en;
        logic rx_data_en;
    } ctrl_t;

    typedef struct packed {
        logic dma_tx;
        logic dma_rx;
        logic irq_tx;
        logic irq_rx;
        logic irq_udr;
        logic irq_ovr;
    } req_t;

endpackage

// File: rtl/sfir_level_flags.sv
module sfir_level_flags #(
    parameter int LVL_W = 5,
    parameter int WM_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [WM_W-1:0]  rx_wm_i,
    input  logic [WM_W-1:0]  tx_wm_i,
    output logic             rx_full_o,
    output logic             tx_empty_o
);

    localparam int PAD_W = LVL_W - WM_W;

    typedef struct packed {
        logic rx_full;
        logic tx_empty;
    } lvl_state_t;

    lvl_state_t st_d, st_q;
    logic [LVL_W-1:0] rx_wm_ext, tx_wm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rx_wm_ext = {{PAD_W{1'b0}}, rx_wm_i};
            assign tx_wm_ext = {{PAD_W{1'b0}}, tx_wm_i};
        end else begin : g_nopad
            assign rx_wm_ext = rx_wm_i[LVL_W-1:0];
            assign tx_wm_ext = tx_wm_i[LVL_W-1:0];
        end
    endgenerate

    always_comb begin
        st_d          = st_q;
        st_d.rx_full  = (rx_level_i >= rx_wm_ext);
        st_d.tx_empty = (tx_level_i <  tx_wm_ext);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_full_o  = st_q.rx_full;
    assign tx_empty_o = st_q.tx_empty;

    assert_rx_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level_i < rx_wm_ext) |=> !rx_full_o);

    assert_tx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level_i >= tx_wm_ext) |=> !tx_empty_o);

endmodule

// File: rtl/sfir_regs.sv
module sfir_regs
    import sfir_pkg::*;
#(
    parameter int WM_W      = 4,
    parameter int RX_WM_RST = 8,
    parameter int TX_WM_RST = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [2*WM_W-1:0]    reg_wdata_i,
    output logic [2*WM_W-1:0]    reg_rdata_o,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic                 rx_full_i,
    input  logic                 tx_empty_i,
    output ctrl_t                ctrl_o,
    output logic [WM_W-1:0]      rx_wm_o,
    output logic [WM_W-1:0]      tx_wm_o,
    output logic [NUM_EVT-1:0]   sticky_o
);

    localparam int REG_W    = 2 * WM_W;
    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int STAT_USE = STAT_EVT_LSB + NUM_EVT;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [WM_W-1:0]    rx_wm;
        logic [WM_W-1:0]    tx_wm;
        logic [NUM_EVT-1:0] sticky;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic wr_ctrl, wr_wm, wr_stat;
    logic [NUM_EVT-1:0] clr;

    assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign wr_wm   = reg_wr_i && (reg_addr_i == ADDR_WM);
    assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STAT);

    generate
        for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
            assign clr[i] = wr_stat && reg_wdata_i[STAT_EVT_LSB+i];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
        end
        if (wr_wm) begin
            st_d.rx_wm = reg_wdata_i[WM_W-1:0];
            st_d.tx_wm = reg_wdata_i[REG_W-1:WM_W];
        end
        for (int i = 0; i < NUM_EVT; i++) begin
            st_d.sticky[i] = evt_i[i] | (st_q.sticky[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rx_wm  <= WM_W'(RX_WM_RST);
            st_q.tx_wm  <= WM_W'(TX_WM_RST);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CTRL: reg_rdata_o[CTRL_W-1:0] = st_q.ctrl;
            ADDR_WM:   reg_rdata_o = {st_q.tx_wm, st_q.rx_wm};
            ADDR_STAT: reg_rdata_o[STAT_USE-1:0] = {st_q.sticky, tx_empty_i, rx_full_i};
            default:   reg_rdata_o = '0;
        endcase
    end

    assign ctrl_o   = st_q.ctrl;
    assign rx_wm_o  = st_q.rx_wm;
    assign tx_wm_o  = st_q.tx_wm;
    assign sticky_o = st_q.sticky;

    assert_ctl_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o[EVT_RX_CTL] && !clr[EVT_RX_CTL]) |=> sticky_o[EVT_RX_CTL]);

    assert_ctl_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[EVT_TX_CTL] |=> sticky_o[EVT_TX_CTL]);

    assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[EVT_RX_OVR] |=> sticky_o[EVT_RX_OVR]);

    assert_err_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[EVT_TX_UDR] && !evt_i[EVT_TX_UDR]) |=> !sticky_o[EVT_TX_UDR]);

endmodule

// File: rtl/sfir_router.sv
module sfir_router
    import sfir_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctrl_i,
    input  logic [NUM_EVT-1:0] sticky_i,
    input  logic               rx_full_i,
    input  logic               tx_empty_i,
    output req_t               req_o
);

    req_t st_d, st_q;
    logic rx_data_on, tx_data_on, rx_ctl_on, tx_ctl_on;

    assign rx_data_on = rx_full_i  && ctrl_i.rx_data_en;
    assign tx_data_on = tx_empty_i && ctrl_i.tx_data_en;
    assign rx_ctl_on  = sticky_i[EVT_RX_CTL] && ctrl_i.rx_ctl_en;
    assign tx_ctl_on  = sticky_i[EVT_TX_CTL] && ctrl_i.tx_ctl_en;

    always_comb begin
        st_d         = st_q;
        st_d.irq_ovr = sticky_i[EVT_RX_OVR];
        st_d.irq_udr = sticky_i[EVT_TX_UDR];
        st_d.irq_rx  = rx_ctl_on || (rx_data_on && !ctrl_i.dma_route);
        st_d.irq_tx  = tx_ctl_on || (tx_data_on && !ctrl_i.dma_route);
        st_d.dma_rx  = rx_data_on && ctrl_i.dma_route;
        st_d.dma_tx  = tx_data_on && ctrl_i.dma_route;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q;

    assert_cpu_mode_no_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.dma_route |=> (!req_o.dma_rx && !req_o.dma_tx));

    assert_dma_mode_data_off_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.dma_route && !rx_ctl_on) |=> !req_o.irq_rx);

    assert_ctl_never_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_data_on |=> !req_o.dma_rx);

    assert_ctl_never_dma_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_data_on |=> !req_o.dma_tx);

    assert_err_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_i[EVT_RX_OVR] && sticky_i[EVT_TX_UDR]) |=> (req_o.irq_ovr && req_o.irq_udr));

endmodule

// File: rtl/sfir_top.sv
module sfir_top
    import sfir_pkg::*;
#(
    parameter int LVL_W     = 5,
    parameter int WM_W      = 4,
    parameter int RX_WM_RST = 8,
    parameter int TX_WM_RST = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LVL_W-1:0]    rx_level,
    input  logic [LVL_W-1:0]    tx_level,
    input  logic                rx_ctl_evt,
    input  logic                tx_ctl_evt,
    input  logic                rx_ovr_evt,
    input  logic                tx_udr_evt,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [2*WM_W-1:0]   reg_wdata,
    output logic [2*WM_W-1:0]   reg_rdata,
    output logic                irq_rx_ovr,
    output logic                irq_tx_udr,
    output logic                irq_rx,
    output logic                irq_tx,
    output logic                dma_rx_req,
    output logic                dma_tx_req
);

    ctrl_t              ctrl;
    logic [WM_W-1:0]    rx_wm, tx_wm;
    logic [NUM_EVT-1:0] sticky, evt;
    logic               rx_full, tx_empty;
    req_t               req;

    always_comb begin
        evt             = '0;
        evt[EVT_RX_CTL] = rx_ctl_evt;
        evt[EVT_TX_CTL] = tx_ctl_evt;
        evt[EVT_RX_OVR] = rx_ovr_evt;
        evt[EVT_TX_UDR] = tx_udr_evt;
    end

    sfir_regs #(
        .WM_W      (WM_W),
        .RX_WM_RST (RX_WM_RST),
        .TX_WM_RST (TX_WM_RST)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .evt_i       (evt),
        .rx_full_i   (rx_full),
        .tx_empty_i  (tx_empty),
        .ctrl_o      (ctrl),
        .rx_wm_o     (rx_wm),
        .tx_wm_o     (tx_wm),
        .sticky_o    (sticky)
    );

    sfir_level_flags #(
        .LVL_W (LVL_W),
        .WM_W  (WM_W)
    ) lvl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_level_i (rx_level),
        .tx_level_i (tx_level),
        .rx_wm_i    (rx_wm),
        .tx_wm_i    (tx_wm),
        .rx_full_o  (rx_full),
        .tx_empty_o (tx_empty)
    );

    sfir_router router_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .sticky_i   (sticky),
        .rx_full_i  (rx_full),
        .tx_empty_i (tx_empty),
        .req_o      (req)
    );

    assign irq_rx_ovr = req.irq_ovr;
    assign irq_tx_udr = req.irq_udr;
    assign irq_rx     = req.irq_rx;
    assign irq_tx     = req.irq_tx;
    assign dma_rx_req = req.dma_rx;
    assign dma_tx_req = req.dma_tx;

    assert_reg_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky[EVT_RX_OVR] |=> !irq_rx_ovr);

endmodule

// File: tb/sfir_top_tb_top.sv
module sfir_top_tb_top;

    localparam int LVL_W = 5;
    localparam int WM_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] tx_level = 5'd10;
    logic             rx_ctl_evt = 1'b0, tx_ctl_evt = 1'b0;
    logic             rx_ovr_evt = 1'b0, tx_udr_evt = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic irq_rx_ovr, irq_tx_udr, irq_rx, irq_tx, dma_rx_req, dma_tx_req;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    typedef struct {
        bit         is_rd;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #10 clk = ~clk;

    sfir_top #(.LVL_W(LVL_W), .WM_W(WM_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_ctl_evt(rx_ctl_evt), .tx_ctl_evt(tx_ctl_evt),
        .rx_ovr_evt(rx_ovr_evt), .tx_udr_evt(tx_udr_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_rx_ovr(irq_rx_ovr), .irq_tx_udr(irq_tx_udr),
        .irq_rx(irq_rx), .irq_tx(irq_tx),
        .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
    );

    // Output vector bits: 5 dma_tx, 4 dma_rx, 3 irq_tx, 2 irq_rx, 1 udr, 0 ovr
    initial begin : monitor
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [7:0] act;
                e = exp_q.pop_front();
                act = e.is_rd ? reg_rdata
                              : {2'b00, dma_tx_req, dma_rx_req, irq_tx, irq_rx, irq_tx_udr, irq_rx_ovr};
                n_checks++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s %s actual=0x%02h expected=0x%02h",
                             e.tag, e.is_rd ? "read" : "outputs", act, e.val);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick(1);
        reg_wr    = 1'b0;
    endtask

    task automatic exp_out(input logic [7:0] v, input string tag);
        exp_t e;
        e.is_rd = 1'b0; e.val = v; e.tag = tag;
        exp_q.push_back(e);
        ->chk_ev;
        #1;
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] v, input string tag);
        exp_t e;
        reg_addr = a;
        #1;
        e.is_rd = 1'b1; e.val = v; e.tag = tag;
        exp_q.push_back(e);
        ->chk_ev;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : driver
        tick(3);
        rst_n = 1'b1;
        exp_out(8'h00, "R1 outputs after reset");
        exp_rd(2'd0, 8'h00, "R1 control after reset");
        exp_rd(2'd1, 8'h88, "R1 watermarks after reset");
        exp_rd(2'd2, 8'h00, "R1 status after reset");
        tick(2);

        // R2: receive ready tracks level >= watermark
        rx_level = 5'd8; tick(1);
        exp_rd(2'd2, 8'h01, "R2 ready at watermark");
        rx_level = 5'd7; tick(1);
        exp_rd(2'd2, 8'h00, "R2 self-clear below watermark");

        // R3: transmit space tracks level < watermark
        tx_level = 5'd7; tick(1);
        exp_rd(2'd2, 8'h02, "R3 space below watermark");
        tx_level = 5'd8; tick(1);
        exp_rd(2'd2, 8'h00, "R3 self-clear at watermark");

        // R6 / R10: CPU mode, data enable
        wr(2'd0, 8'h01);
        rx_level = 5'd9; tick(1);
        exp_out(8'h00, "R10 output not yet updated");
        tick(1);
        exp_out(8'h04, "R6 receive data to CPU");

        // R7: DMA routing
        wr(2'd0, 8'h11);
        tick(1);
        exp_out(8'h10, "R7 receive data to DMA");
        rx_level = 5'd3; tick(2);
        exp_out(8'h00, "R2 DMA request drops as FIFO drains");

        // R8 / R4: control flag stays with CPU
        wr(2'd0, 8'h12);
        rx_ctl_evt = 1'b1; tick(1); rx_ctl_evt = 1'b0; tick(1);
        exp_out(8'h04, "R8 control word to CPU not DMA");
        tick(3);
        exp_out(8'h04, "R4 control flag sticky");
        exp_rd(2'd2, 8'h04, "R4 control flag in status");
        wr(2'd2, 8'h04);
        tick(1);
        exp_out(8'h00, "R4 write-one clear");
        exp_rd(2'd2, 8'h00, "R4 status after clear");

        // R7 / R8: transmit side in DMA mode
        wr(2'd0, 8'h1C);
        tx_level = 5'd2;
        tx_ctl_evt = 1'b1; tick(1); tx_ctl_evt = 1'b0; tick(1);
        exp_out(8'h28, "R7 transmit data to DMA, control to CPU");
        wr(2'd0, 8'h0C);
        tick(1);
        exp_out(8'h08, "R6 transmit back on CPU line");
        wr(2'd0, 8'h00);
        tick(1);
        exp_out(8'h00, "R9 all enables off");
        exp_rd(2'd2, 8'h0A, "R9 flags untouched by enables");

        // R5: error interrupts need no enable
        rx_ovr_evt = 1'b1; tick(1); rx_ovr_evt = 1'b0; tick(1);
        exp_out(8'h01, "R5 overrun interrupt");
        tx_udr_evt = 1'b1; tick(1); tx_udr_evt = 1'b0; tick(1);
        exp_out(8'h03, "R5 underrun interrupt");
        wr(2'd2, 8'h10);
        tick(1);
        exp_out(8'h02, "R5 overrun cleared");

        // R5 / R4: set wins over simultaneous clear
        reg_addr = 2'd2; reg_wdata = 8'h20; reg_wr = 1'b1; tx_udr_evt = 1'b1;
        tick(1);
        reg_wr = 1'b0; tx_udr_evt = 1'b0;
        tick(1);
        exp_out(8'h02, "R5 pulse beats clear");
        exp_rd(2'd2, 8'h2A, "R4 status after set-wins");

        // R2 / R3: reprogrammed watermarks
        wr(2'd1, 8'h32);
        tick(1);
        exp_rd(2'd1, 8'h32, "R2 watermark readback");
        exp_rd(2'd2, 8'h2B, "R2 ready with new watermark");
        exp_out(8'h02, "R9 ready flag gated off");
        tx_level = 5'd3; tick(1);
        exp_rd(2'd2, 8'h29, "R3 self-clear at new watermark");

        tick(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule